// File: doc/BRIEF.md
# Two-Symbol Comma Word Aligner

This block sits on the receive side of an 8b10b-coded serial lane, right after a deserializer that delivers two 10-bit symbols per clock. The deserializer runs free, so the boundaries of the 20-bit words it delivers can sit at any bit position in the line stream. The aligner looks for the K28.5 comma pattern in both running-disparity forms. It then selects a bit offset such that every output word starts on a comma boundary, with the comma in the low (even) symbol slot. The two bytes therefore never reach the decoder swapped.

Matching works on the raw 10-bit pattern, not on decoded characters. Other control symbols, and data bytes that decode to the same byte value as the comma, pass through unchanged. A per-symbol flag reports where the comma pattern was seen, so that the downstream decoder can tell a comma from data. An optional pair mode accepts an alignment event only when both symbols of the word hold a comma. This fixes the 16-bit boundary unambiguously.

After the first accepted comma the offset is held. It moves only after the same new offset has been seen on several comma events in a row, and each such move is marked by a one-cycle pulse.

Top module: `comma_word_aligner`

## Requirements
- R1: The comma is recognised in either form. With bit a at index 0 and bit j at index 9 of a symbol, the two forms are 10'b0101111100 and 10'b1010000011. Within each input word, bit index 0 is the earliest received bit.
- R2: The search covers all 20 offsets k (0..19) over a 40-bit window, which holds the newer word in the upper half and the older word in the lower half. An offset qualifies when window bits k..k+9 hold a comma. When several offsets qualify, the lowest one is taken.
- R3: From the cycle that lock is first reported, word_o[9:0] holds the comma that caused the lock. Every following word_o is window bits off..off+19, so the symbols keep the order in which they were received.
- R4: With dbl_mode_i high, an offset qualifies only when both window bits k..k+9 and bits k+10..k+19 hold a comma. A single comma causes no lock. When lock comes from a pair, comma_o reads 2'b11.
- R5: comma_o[s] is high exactly when output symbol s (word_o[10s+9:10s]) matches a comma form. Other control symbols, such as 10'b0010111100, and the data symbol 10'b0101011100 pass through unchanged with their flag low.
- R6: Once locked, the block stays locked until reset, and its offset stays fixed as long as fewer than three consecutive comma events land at one other offset. Words that contain no qualifying comma neither advance nor clear the count.
- R7: On the third consecutive comma event at the same new offset, the offset moves to that value. realign_o is high for exactly one cycle, on the first output word taken at the new offset, and that word has a comma in its low symbol.
- R8: Reset (rst_ni low, asynchronous) clears lock, offset and outputs. While unlocked, word_o and comma_o are zero and realign_o is low.
- R9: Latency is two register stages. A word presented before clock edge t enters the window at edge t. The output computed from that window appears after edge t+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_word_i | input | 20 | Raw deserialized word; bit 0 is the earliest bit |
| dbl_mode_i | input | 1 | High: only a comma pair qualifies as an alignment event |
| word_o | output | 20 | Aligned word; low symbol is the even slot |
| comma_o | output | 2 | Per-symbol comma pattern flag |
| locked_o | output | 1 | Lock achieved; output word valid |
| realign_o | output | 1 | One-cycle pulse when the offset moves |

## Verification
Some properties hold on every cycle, and the assertions check those. While unlocked the output is blanked. Lock never drops. The lock-up word carries a comma in its low slot, or a comma in both slots in pair mode. The comma flags agree with the output symbols. The realign pulse lasts one cycle and coincides with a comma-led word. Other behaviour only the bench scenarios can show. That covers choosing the lowest of two competing offsets, ignoring a lone comma in pair mode, and refusing to move on two stray commas while moving on the third. It also covers the exact two-cycle latency, which the bench tracks against its own window model across random bit slips.

// File: rtl/cwa_pkg.sv
package cwa_pkg;

  localparam int SYM_W = 10;

  // Comma in both running-disparity forms, bit a at index 0
  localparam logic [SYM_W-1:0] CM_FORM_P = 10'b0101111100;
  localparam logic [SYM_W-1:0] CM_FORM_N = 10'b1010000011;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_HOLD = 1'b1
  } lock_st_e;

  function automatic logic is_comma(input logic [SYM_W-1:0] sym);
    return (sym == CM_FORM_P) || (sym == CM_FORM_N);
  endfunction

endpackage

// File: rtl/cwa_comma_scan.sv
module cwa_comma_scan #(
  parameter int NSYM   = 2,
  parameter int WORD_W = cwa_pkg::SYM_W * NSYM,
  parameter int OFF_W  = $clog2(WORD_W)
) (
  input  logic [2*WORD_W-1:0] win_i,
  input  logic                dbl_i,
  output logic                hit_o,
  output logic [OFF_W-1:0]    off_o
);
  import cwa_pkg::*;

  logic [WORD_W-1:0] qual;

  for (genvar k = 0; k < WORD_W; k++) begin : g_off
    logic [NSYM-1:0] sym_m;
    for (genvar s = 0; s < NSYM; s++) begin : g_sym
      assign sym_m[s] = is_comma(win_i[k + s*SYM_W +: SYM_W]);
    end
    assign qual[k] = dbl_i ? (&sym_m) : sym_m[0];
  end

  // lowest qualifying offset wins
  always_comb begin
    hit_o = 1'b0;
    off_o = '0;
    for (int k = WORD_W - 1; k >= 0; k--) begin
      if (qual[k]) begin
        hit_o = 1'b1;
        off_o = OFF_W'(k);
      end
    end
  end

endmodule

// File: rtl/cwa_lock_ctrl.sv
module cwa_lock_ctrl #(
  parameter int OFF_W      = 5,
  parameter int RELOCK_CNT = 3,
  localparam int CNT_W     = $clog2(RELOCK_CNT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic [OFF_W-1:0] cand_i,
  output logic             locked_o,
  output logic             lock_nxt_o,
  output logic [OFF_W-1:0] off_nxt_o,
  output logic             realign_nxt_o
);
  import cwa_pkg::*;

  lock_st_e           st_q, st_d;
  logic [OFF_W-1:0]   off_q, off_d;
  logic [OFF_W-1:0]   pend_q, pend_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [CNT_W-1:0]   run;
  logic               realign_d;

  always_comb begin
    st_d      = st_q;
    off_d     = off_q;
    pend_d    = pend_q;
    cnt_d     = cnt_q;
    realign_d = 1'b0;
    run       = CNT_W'(1);
    if (hit_i) begin
      unique case (st_q)
        ST_HUNT: begin
          st_d  = ST_HOLD;
          off_d = cand_i;
          cnt_d = '0;
        end
        ST_HOLD: begin
          if (cand_i == off_q) begin
            cnt_d = '0;
          end else begin
            if ((cnt_q != '0) && (cand_i == pend_q)) run = cnt_q + 1'b1;
            if (run >= CNT_W'(RELOCK_CNT)) begin
              off_d     = cand_i;
              cnt_d     = '0;
              realign_d = 1'b1;
            end else begin
              pend_d = cand_i;
              cnt_d  = run;
            end
          end
        end
        default: st_d = ST_HUNT;
      endcase
    end
  end

  // clock enable: state only advances on a qualifying comma
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_HUNT;
      off_q  <= '0;
      pend_q <= '0;
      cnt_q  <= '0;
    end else if (hit_i) begin
      st_q   <= st_d;
      off_q  <= off_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  assign locked_o      = (st_q == ST_HOLD);
  assign lock_nxt_o    = (st_d == ST_HOLD);
  assign off_nxt_o     = off_d;
  assign realign_nxt_o = realign_d;

endmodule

// File: rtl/cwa_shifter.sv
module cwa_shifter #(
  parameter int NSYM   = 2,
  parameter int WORD_W = cwa_pkg::SYM_W * NSYM,
  parameter int OFF_W  = $clog2(WORD_W),
  localparam int IDX_W = $clog2(2 * WORD_W)
) (
  input  logic [2*WORD_W-1:0] win_i,
  input  logic [OFF_W-1:0]    off_i,
  input  logic                en_i,
  output logic [WORD_W-1:0]   word_o,
  output logic [NSYM-1:0]     comma_o
);
  import cwa_pkg::*;

  logic [IDX_W-1:0] idx;

  assign idx    = IDX_W'(off_i);
  assign word_o = en_i ? win_i[idx +: WORD_W] : '0;

  for (genvar s = 0; s < NSYM; s++) begin : g_flag
    assign comma_o[s] = is_comma(word_o[s*SYM_W +: SYM_W]);
  end

endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner #(
  parameter int  NSYM       = 2,
  parameter int  RELOCK_CNT = 3,
  localparam int WORD_W     = cwa_pkg::SYM_W * NSYM,
  localparam int OFF_W      = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] rx_word_i,
  input  logic              dbl_mode_i,
  output logic [WORD_W-1:0] word_o,
  output logic [NSYM-1:0]   comma_o,
  output logic              locked_o,
  output logic              realign_o
);

  logic [WORD_W-1:0]   cur_q, prev_q;
  logic [2*WORD_W-1:0] win;
  logic                hit;
  logic [OFF_W-1:0]    cand;
  logic                lock_nxt;
  logic [OFF_W-1:0]    off_nxt;
  logic                realign_nxt;
  logic [WORD_W-1:0]   word_d, word_q;
  logic [NSYM-1:0]     comma_d, comma_q;
  logic                realign_q;

  // input stage: newer word on top, older word below
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      cur_q  <= rx_word_i;
      prev_q <= cur_q;
    end
  end

  assign win = {cur_q, prev_q};

  cwa_comma_scan #(
    .NSYM   (NSYM),
    .WORD_W (WORD_W),
    .OFF_W  (OFF_W)
  ) u_scan (
    .win_i (win),
    .dbl_i (dbl_mode_i),
    .hit_o (hit),
    .off_o (cand)
  );

  cwa_lock_ctrl #(
    .OFF_W      (OFF_W),
    .RELOCK_CNT (RELOCK_CNT)
  ) u_lock (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .hit_i         (hit),
    .cand_i        (cand),
    .locked_o      (locked_o),
    .lock_nxt_o    (lock_nxt),
    .off_nxt_o     (off_nxt),
    .realign_nxt_o (realign_nxt)
  );

  cwa_shifter #(
    .NSYM   (NSYM),
    .WORD_W (WORD_W),
    .OFF_W  (OFF_W)
  ) u_shift (
    .win_i   (win),
    .off_i   (off_nxt),
    .en_i    (lock_nxt),
    .word_o  (word_d),
    .comma_o (comma_d)
  );

  // output stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q    <= '0;
      comma_q   <= '0;
      realign_q <= 1'b0;
    end else begin
      word_q    <= word_d;
      comma_q   <= comma_d;
      realign_q <= realign_nxt;
    end
  end

  assign word_o    = word_q;
  assign comma_o   = comma_q;
  assign realign_o = realign_q;

endmodule

// File: rtl/comma_word_aligner_sva.sv
module cwa_checker #(
  parameter int NSYM   = 2,
  parameter int WORD_W = cwa_pkg::SYM_W * NSYM
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dbl_mode_i,
  input logic [WORD_W-1:0] word_o,
  input logic [NSYM-1:0]   comma_o,
  input logic              locked_o,
  input logic              realign_o
);
  import cwa_pkg::*;

  p_blank_unlocked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_o |-> (word_o == '0 && comma_o == '0 && !realign_o));

  p_low_comma_on_lock_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> comma_o[0]);

  p_pair_on_lock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(locked_o) && $past(dbl_mode_i)) |-> (&comma_o));

  p_flag_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comma_o[0] == is_comma(word_o[SYM_W-1:0]));

  p_flag_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comma_o[NSYM-1] == is_comma(word_o[WORD_W-1 -: SYM_W]));

  p_lock_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> locked_o);

  p_realign_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    realign_o |=> !realign_o);

  p_realign_aligned_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    realign_o |-> (locked_o && $past(locked_o) && comma_o[0]));

endmodule

bind comma_word_aligner cwa_checker #(
  .NSYM   (NSYM),
  .WORD_W (WORD_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dbl_mode_i (dbl_mode_i),
  .word_o     (word_o),
  .comma_o    (comma_o),
  .locked_o   (locked_o),
  .realign_o  (realign_o)
);

// File: tb/comma_word_aligner_tb.sv
module comma_word_aligner_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] CM_P = 10'b0101111100;
  localparam logic [9:0] CM_N = 10'b1010000011;
  localparam logic [9:0] FILL = 10'b1010101010;
  localparam logic [9:0] K_OTHER = 10'b0010111100;
  localparam logic [9:0] D_BC = 10'b0101011100;

  logic        clk, rst_ni;
  logic [19:0] rx_word;
  logic        dbl_mode;
  logic [19:0] word_o;
  logic [1:0]  comma_o;
  logic        locked_o, realign_o;

  comma_word_aligner u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .rx_word_i  (rx_word),
    .dbl_mode_i (dbl_mode),
    .word_o     (word_o),
    .comma_o    (comma_o),
    .locked_o   (locked_o),
    .realign_o  (realign_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp, n_bad;
  bit done;

  // bench reference state
  logic [19:0] h0, h1;
  bit          m_lk;
  int          m_off, m_pend, m_cnt;
  logic [19:0] e_word;
  logic [1:0]  e_comma;
  bit          e_lk, e_rl;
  bit          cur_dbl;
  logic [99:0] bb;
  int          bn;
  int          rl_seen;
  bit          prev_lk;
  logic [19:0] lk_word, rl_word, watch_w;
  logic [1:0]  lk_comma, watch_c;
  bit          watch_hit;

  function automatic bit cm(input logic [9:0] s);
    return (s == CM_P) || (s == CM_N);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_step(input bit dbl);
    logic [39:0] win;
    bit hit;
    int k, run;
    win = {h1, h0};
    hit = 1'b0;
    k = 0;
    for (int i = 19; i >= 0; i--) begin
      bit one, two;
      one = cm(win[i +: 10]);
      two = one && cm(win[i+10 +: 10]);
      if (dbl ? two : one) begin
        hit = 1'b1;
        k = i;
      end
    end
    e_rl = 1'b0;
    if (hit && !m_lk) begin
      m_lk = 1'b1; m_off = k; m_cnt = 0;
    end else if (hit) begin
      if (k == m_off) m_cnt = 0;
      else begin
        run = (m_cnt != 0 && k == m_pend) ? m_cnt + 1 : 1;
        if (run >= 3) begin
          m_off = k; m_cnt = 0; e_rl = 1'b1;
        end else begin
          m_pend = k; m_cnt = run;
        end
      end
    end
    e_lk    = m_lk;
    e_word  = m_lk ? win[m_off +: 20] : 20'h0;
    e_comma = {cm(e_word[19:10]), cm(e_word[9:0])};
  endtask

  // starts and ends at a falling edge
  task automatic tick(input logic [19:0] w);
    rx_word  = w;
    dbl_mode = cur_dbl;
    model_step(cur_dbl);
    h0 = h1;
    h1 = w;
    @(posedge clk);
    @(negedge clk);
    check(word_o == e_word, "R9", "word_o", 32'(word_o), 32'(e_word));
    check(comma_o == e_comma, "R5", "comma_o", 32'(comma_o), 32'(e_comma));
    check(locked_o == e_lk, "R6", "locked_o", 32'(locked_o), 32'(e_lk));
    check(realign_o == e_rl, "R7", "realign_o", 32'(realign_o), 32'(e_rl));
    if (realign_o) begin
      rl_seen++;
      rl_word = word_o;
    end
    if (locked_o && !prev_lk) begin
      lk_word  = word_o;
      lk_comma = comma_o;
    end
    if (word_o == watch_w && comma_o == watch_c) watch_hit = 1'b1;
    prev_lk = locked_o;
  endtask

  task automatic push_bits(input logic [19:0] v, input int n);
    logic [19:0] m;
    m = (n >= 20) ? 20'hFFFFF : ((20'h1 << n) - 20'h1);
    bb = bb | (100'(v & m) << bn);
    bn += n;
    while (bn >= 20) begin
      logic [19:0] w;
      w = bb[19:0];
      bb = bb >> 20;
      bn -= 20;
      tick(w);
    end
  endtask

  task automatic send_sym(input logic [9:0] s);
    push_bits(20'(s), 10);
  endtask

  task automatic fills(input int n);
    for (int i = 0; i < n; i++) send_sym(FILL);
  endtask

  task automatic do_reset();
    rst_ni   = 1'b0;
    rx_word  = '0;
    dbl_mode = cur_dbl;
    @(negedge clk);
    @(negedge clk);
    check(locked_o == 1'b0, "R8", "locked_o in reset", 32'(locked_o), 32'h0);
    check(word_o == '0, "R8", "word_o in reset", 32'(word_o), 32'h0);
    check(comma_o == '0 && realign_o == 1'b0, "R8", "flags in reset",
          {30'h0, comma_o} | {31'h0, realign_o}, 32'h0);
    h0 = '0; h1 = '0;
    m_lk = 1'b0; m_off = 0; m_pend = 0; m_cnt = 0;
    bb = '0; bn = 0;
    prev_lk = 1'b0;
    rst_ni = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired, all requirements unfinished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5713));
    n_cmp = 0; n_bad = 0; done = 1'b0; rl_seen = 0;
    cur_dbl = 1'b0;
    watch_w = 20'hFFFFF; watch_c = 2'b00; watch_hit = 1'b0;
    @(negedge clk);
    do_reset();

    // R8/R2: no comma anywhere -> no lock, output blank
    fills(20);
    check(locked_o == 1'b0, "R8", "unlocked without comma", 32'(locked_o), 32'h0);
    check(word_o == '0, "R8", "blank while unlocked", 32'(word_o), 32'h0);

    // R1/R2/R3: minus form then plus form, slip 3; lowest offset (the minus one) wins
    push_bits(20'hAAAAA, 3);
    send_sym(CM_N);
    send_sym(CM_P);
    fills(6);
    check(locked_o == 1'b1, "R1", "locked on comma", 32'(locked_o), 32'h1);
    check(lk_word[9:0] == CM_N, "R2", "lowest offset comma in low slot", 32'(lk_word[9:0]), 32'(CM_N));
    check(lk_word[19:10] == CM_P, "R3", "second comma in high slot", 32'(lk_word[19:10]), 32'(CM_P));
    check(lk_comma == 2'b11, "R5", "both flags on lock word", 32'(lk_comma), 32'h3);

    // R5: other control symbol and data 0xBC pass untouched, flags low
    watch_w = {D_BC, K_OTHER}; watch_c = 2'b00; watch_hit = 1'b0;
    send_sym(K_OTHER);
    send_sym(D_BC);
    fills(6);
    check(watch_hit, "R5", "K and 0xBC data unchanged", 32'(watch_hit), 32'h1);

    // R6/R7: shift alignment by 7 bits, commas at new offset
    push_bits(20'h55555, 7);
    for (int r = 0; r < 2; r++) begin
      send_sym(CM_P);
      fills(5);
    end
    check(rl_seen == 0, "R6", "no move after two stray commas", 32'(rl_seen), 32'h0);
    check(locked_o == 1'b1, "R6", "lock held", 32'(locked_o), 32'h1);
    send_sym(CM_P);
    fills(5);
    check(rl_seen == 1, "R7", "one realign pulse", 32'(rl_seen), 32'h1);
    check(rl_word[9:0] == CM_P, "R7", "comma low on realign word", 32'(rl_word[9:0]), 32'(CM_P));

    // R4: pair mode
    cur_dbl = 1'b1;
    do_reset();
    fills(4);
    push_bits(20'hAAAAA, 5);
    send_sym(CM_P);
    fills(7);
    check(locked_o == 1'b0, "R4", "single comma ignored in pair mode", 32'(locked_o), 32'h0);
    send_sym(CM_P);
    send_sym(CM_N);
    fills(6);
    check(locked_o == 1'b1, "R4", "pair locks", 32'(locked_o), 32'h1);
    check(lk_comma == 2'b11, "R4", "pair flags", 32'(lk_comma), 32'h3);
    check(lk_word == {CM_N, CM_P}, "R4", "pair word", 32'(lk_word), 32'({CM_N, CM_P}));

    // random segments, every cycle compared against the bench model
    for (int seg = 0; seg < 40; seg++) begin
      int nsym;
      if (($urandom % 8) == 0) do_reset();
      cur_dbl = (($urandom % 3) == 0);
      push_bits(20'($urandom), int'($urandom % 20));
      nsym = 30 + int'($urandom % 30);
      for (int i = 0; i < nsym; i++) begin
        int pick;
        logic [9:0] s;
        pick = int'($urandom % 100);
        if (pick < 12) begin
          s = ($urandom % 2) ? CM_P : CM_N;
          send_sym(s);
          if (cur_dbl) send_sym(($urandom % 2) ? CM_P : CM_N);
        end else if (pick < 50) begin
          send_sym(FILL);
        end else begin
          s = 10'($urandom);
          if (cm(s)) s = FILL;
          send_sym(s);
        end
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule